// File: doc/BRIEF.md
# Programmable Video Raster Timing Engine

This block generates the raster timing for a video-mode panel from values that software writes into registers. A horizontal counter wraps once per line. A second counter runs linearly across the whole frame, counting pixel clocks. Vertical sync and the vertical display window are therefore set as pixel-clock offsets from the start of the frame, not as line numbers. The block drives hsync, vsync, data-enable and a pixel bus. It applies a separate polarity to each sync signal and truncates each colour component to the depth of the panel.

Pixels come in on a valid/ready port. The port is ready exactly while the raster is inside the display window. When no pixel is offered during the window, a programmable underflow colour is sent instead. Outside the window a border colour is sent. A frame counter and a line counter are available as outputs for readback. Timing registers are double-buffered, so that a frame never runs with a mix of old and new timing. When the engine is switched off, it stops only at the end of the current frame.

Top module: `vid_timing_engine`

## Requirements
- R1: While reset is held and after it is released, with no register written, hsyncOut, vsyncOut, deOut and inReady are 0, pixOut is 0, and frameCount and lineCount are 0.
- R2: Register 0 holds the line period in bits [15:0] and the hsync pulse width in bits [31:16], both in pixel clocks. While running, the raw hsync is active during the first pulse-width clocks of every line, and a line lasts the period. Each output follows its counter state one clock later.
- R3: Register 1 holds the frame length in pixel clocks and register 2 holds the vsync length in pixel clocks. While running, the raw vsync is active for the first vsync-length clocks of every frame.
- R4: Register 3 holds the horizontal window start in [15:0] and end in [31:16]. Registers 4 and 5 hold the vertical window start and end as linear pixel counts. deOut is high only when the line position is within [start, end] and the frame position is within the vertical window, both bounds inclusive.
- R5: Register 6 holds a skew that is added to both vertical window bounds. Its reset value is 0.
- R6: In register 7, bit 0 makes hsyncOut active-low and bit 1 makes vsyncOut active-low. Each bit applies to its own signal only.
- R7: inReady equals the in-window condition of the current cycle. On the next clock, pixOut shows the input pixel if inValid was high, the underflow colour (register 9) if inValid was low inside the window, and the border colour (register 8) outside the window or while the engine is idle.
- R8: Register 10 carries a 2-bit depth code for each 8-bit component: bits [1:0] for pixel bits [7:0], [3:2] for [15:8] and [5:4] for [23:16]. The codes 0, 1, 2 and 3 keep the top 4, 5, 6 and 8 bits, and the lower bits become 0.
- R9: Bit 0 of register 11 enables the engine. Setting it starts a frame on the next clock. Clearing it mid-frame lets the frame finish, and the engine goes idle at the frame boundary.
- R10: Writes to registers 0 through 6 take effect only when a frame starts, whether that is the start from idle or the wrap at the end of a frame.
- R11: If bit 0 of register 12 is set, frameCount increments by one at each frame start. It holds its value while the engine is idle.
- R12: If bit 1 of register 12 is set, lineCount clears at each frame start and increments at each other line start. If the bit is clear, lineCount holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register index |
| wrData | input | 32 | Register write data |
| inValid | input | 1 | Input pixel valid |
| inPixel | input | 24 | Input pixel, three 8-bit components |
| inReady | output | 1 | Pixel accepted this cycle (in display window) |
| hsyncOut | output | 1 | Horizontal sync, polarity applied |
| vsyncOut | output | 1 | Vertical sync, polarity applied |
| deOut | output | 1 | Data enable |
| pixOut | output | 24 | Output pixel after colour selection and truncation |
| frameCount | output | 16 | Frame counter |
| lineCount | output | 12 | Line counter |

## Verification
The assertions assume that software programs a sane raster. The line period and the frame length are non-zero. The frame length is a whole number of lines. The window bounds lie inside the line and inside the frame. The stimulus only writes such values, including when it changes the timing mid-frame to exercise the shadow copy. The handshake checks assume only that inValid and inPixel are stable around the clock edge, so the bench drives them on the falling edge.

// File: rtl/vte_pkg.sv
package vte_pkg;
  localparam logic [3:0] A_HCTL   = 4'd0;
  localparam logic [3:0] A_FRAME  = 4'd1;
  localparam logic [3:0] A_VSLEN  = 4'd2;
  localparam logic [3:0] A_HWIN   = 4'd3;
  localparam logic [3:0] A_VSTART = 4'd4;
  localparam logic [3:0] A_VEND   = 4'd5;
  localparam logic [3:0] A_SKEW   = 4'd6;
  localparam logic [3:0] A_POL    = 4'd7;
  localparam logic [3:0] A_BORDER = 4'd8;
  localparam logic [3:0] A_UNDER  = 4'd9;
  localparam logic [3:0] A_FMT    = 4'd10;
  localparam logic [3:0] A_EN     = 4'd11;
  localparam logic [3:0] A_CNTEN  = 4'd12;

  // strobes from control to datapath, raw (before polarity)
  typedef struct packed {
    logic run;
    logic hsync;
    logic vsync;
    logic de;
    logic lineStart;
    logic frameStart;
  } vteStrobe_t;
endpackage

// File: rtl/vte_regs.sv
module vte_regs #(
  parameter int HW = 12,
  parameter int VW = 24,
  parameter int PIX_W = 24,
  parameter int NCOMP = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [3:0]        wrAddr,
  input  logic [31:0]       wrData,
  output logic [HW-1:0]     pendHPer,
  output logic [HW-1:0]     pendHPulse,
  output logic [HW-1:0]     pendHStart,
  output logic [HW-1:0]     pendHEnd,
  output logic [VW-1:0]     pendFrame,
  output logic [VW-1:0]     pendVsLen,
  output logic [VW-1:0]     pendVStart,
  output logic [VW-1:0]     pendVEnd,
  output logic [VW-1:0]     pendSkew,
  output logic [1:0]        polBits,
  output logic [PIX_W-1:0]  borderColor,
  output logic [PIX_W-1:0]  underColor,
  output logic [2*NCOMP-1:0] fmtCodes,
  output logic              engEn,
  output logic [1:0]        cntEn
);
  import vte_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      pendHPer    <= '0;
      pendHPulse  <= '0;
      pendHStart  <= '0;
      pendHEnd    <= '0;
      pendFrame   <= '0;
      pendVsLen   <= '0;
      pendVStart  <= '0;
      pendVEnd    <= '0;
      pendSkew    <= '0;
      polBits     <= '0;
      borderColor <= '0;
      underColor  <= '0;
      fmtCodes    <= '1;
      engEn       <= 1'b0;
      cntEn       <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        A_HCTL: begin
          pendHPer   <= wrData[HW-1:0];
          pendHPulse <= wrData[16 +: HW];
        end
        A_FRAME:  pendFrame  <= wrData[VW-1:0];
        A_VSLEN:  pendVsLen  <= wrData[VW-1:0];
        A_HWIN: begin
          pendHStart <= wrData[HW-1:0];
          pendHEnd   <= wrData[16 +: HW];
        end
        A_VSTART: pendVStart <= wrData[VW-1:0];
        A_VEND:   pendVEnd   <= wrData[VW-1:0];
        A_SKEW:   pendSkew   <= wrData[VW-1:0];
        A_POL:    polBits    <= wrData[1:0];
        A_BORDER: borderColor <= wrData[PIX_W-1:0];
        A_UNDER:  underColor  <= wrData[PIX_W-1:0];
        A_FMT:    fmtCodes   <= wrData[2*NCOMP-1:0];
        A_EN:     engEn      <= wrData[0];
        A_CNTEN:  cntEn      <= wrData[1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vte_ctrl.sv
module vte_ctrl #(
  parameter int HW = 12,
  parameter int VW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          engEn,
  input  logic [HW-1:0] pendHPer,
  input  logic [HW-1:0] pendHPulse,
  input  logic [HW-1:0] pendHStart,
  input  logic [HW-1:0] pendHEnd,
  input  logic [VW-1:0] pendFrame,
  input  logic [VW-1:0] pendVsLen,
  input  logic [VW-1:0] pendVStart,
  input  logic [VW-1:0] pendVEnd,
  input  logic [VW-1:0] pendSkew,
  output vte_pkg::vteStrobe_t strobe
);
  logic          running;
  logic [HW-1:0] hCnt;
  logic [VW-1:0] vCnt;
  logic [HW-1:0] actHPer, actHPulse, actHStart, actHEnd;
  logic [VW-1:0] actFrame, actVsLen, actVStart, actVEnd, actSkew;

  logic          lineEnd, frameEnd, loadTiming;
  logic [VW:0]   vLo, vHi;
  logic          hIn, vIn;

  assign lineEnd    = ({1'b0, hCnt} + 1'b1) >= {1'b0, actHPer};
  assign frameEnd   = running && (({1'b0, vCnt} + 1'b1) >= {1'b0, actFrame});
  assign loadTiming = (!running && engEn) || frameEnd;

  always_ff @(posedge clk) begin
    if (rst) begin
      running   <= 1'b0;
      hCnt      <= '0;
      vCnt      <= '0;
      actHPer   <= '0;
      actHPulse <= '0;
      actHStart <= '0;
      actHEnd   <= '0;
      actFrame  <= '0;
      actVsLen  <= '0;
      actVStart <= '0;
      actVEnd   <= '0;
      actSkew   <= '0;
    end else begin
      if (loadTiming) begin
        actHPer   <= pendHPer;
        actHPulse <= pendHPulse;
        actHStart <= pendHStart;
        actHEnd   <= pendHEnd;
        actFrame  <= pendFrame;
        actVsLen  <= pendVsLen;
        actVStart <= pendVStart;
        actVEnd   <= pendVEnd;
        actSkew   <= pendSkew;
        hCnt      <= '0;
        vCnt      <= '0;
      end else if (running) begin
        hCnt <= lineEnd ? '0 : hCnt + 1'b1;
        vCnt <= vCnt + 1'b1;
      end
      if (!running && engEn) running <= 1'b1;
      else if (frameEnd && !engEn) running <= 1'b0;
    end
  end

  assign vLo = {1'b0, actVStart} + {1'b0, actSkew};
  assign vHi = {1'b0, actVEnd} + {1'b0, actSkew};
  assign hIn = (hCnt >= actHStart) && (hCnt <= actHEnd);
  assign vIn = ({1'b0, vCnt} >= vLo) && ({1'b0, vCnt} <= vHi);

  always_comb begin
    strobe.run        = running;
    strobe.hsync      = running && (hCnt < actHPulse);
    strobe.vsync      = running && (vCnt < actVsLen);
    strobe.de         = running && hIn && vIn;
    strobe.lineStart  = running && (hCnt == '0);
    strobe.frameStart = running && (vCnt == '0);
  end
endmodule

// File: rtl/vte_datapath.sv
module vte_datapath #(
  parameter int CW = 8,
  parameter int NCOMP = 3,
  parameter int FW = 16,
  parameter int LW = 12,
  localparam int PIX_W = CW * NCOMP
) (
  input  logic               clk,
  input  logic               rst,
  input  vte_pkg::vteStrobe_t strobe,
  input  logic [1:0]         polBits,
  input  logic [PIX_W-1:0]   borderColor,
  input  logic [PIX_W-1:0]   underColor,
  input  logic [2*NCOMP-1:0] fmtCodes,
  input  logic [1:0]         cntEn,
  input  logic               inValid,
  input  logic [PIX_W-1:0]   inPixel,
  output logic               hsyncOut,
  output logic               vsyncOut,
  output logic               deOut,
  output logic [PIX_W-1:0]   pixOut,
  output logic [FW-1:0]      frameCount,
  output logic [LW-1:0]      lineCount
);
  logic [PIX_W-1:0] selPix, truncPix;

  always_comb begin
    if (!strobe.de)   selPix = borderColor;
    else if (inValid) selPix = inPixel;
    else              selPix = underColor;
  end

  for (genvar c = 0; c < NCOMP; c++) begin : g_comp
    int keep;
    logic [CW-1:0] mask;
    always_comb begin
      case (fmtCodes[2*c +: 2])
        2'd0:    keep = 4;
        2'd1:    keep = 5;
        2'd2:    keep = 6;
        default: keep = 8;
      endcase
      if (keep >= CW) mask = '1;
      else            mask = ~((CW'(1) << (CW - keep)) - CW'(1));
    end
    assign truncPix[c*CW +: CW] = selPix[c*CW +: CW] & mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsyncOut   <= 1'b0;
      vsyncOut   <= 1'b0;
      deOut      <= 1'b0;
      pixOut     <= '0;
      frameCount <= '0;
      lineCount  <= '0;
    end else begin
      hsyncOut <= strobe.hsync ^ polBits[0];
      vsyncOut <= strobe.vsync ^ polBits[1];
      deOut    <= strobe.de;
      pixOut   <= truncPix;
      if (cntEn[0] && strobe.frameStart) frameCount <= frameCount + 1'b1;
      if (cntEn[1]) begin
        if (strobe.frameStart)     lineCount <= '0;
        else if (strobe.lineStart) lineCount <= lineCount + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vid_timing_engine.sv
module vid_timing_engine #(
  parameter int HW = 12,
  parameter int VW = 24,
  parameter int CW = 8,
  parameter int NCOMP = 3,
  parameter int FW = 16,
  parameter int LW = 12,
  localparam int PIX_W = CW * NCOMP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [3:0]       wrAddr,
  input  logic [31:0]      wrData,
  input  logic             inValid,
  input  logic [PIX_W-1:0] inPixel,
  output logic             inReady,
  output logic             hsyncOut,
  output logic             vsyncOut,
  output logic             deOut,
  output logic [PIX_W-1:0] pixOut,
  output logic [FW-1:0]    frameCount,
  output logic [LW-1:0]    lineCount
);
  logic [HW-1:0] pendHPer, pendHPulse, pendHStart, pendHEnd;
  logic [VW-1:0] pendFrame, pendVsLen, pendVStart, pendVEnd, pendSkew;
  logic [1:0]    polBits, cntEn;
  logic [PIX_W-1:0] borderColor, underColor;
  logic [2*NCOMP-1:0] fmtCodes;
  logic engEn;
  vte_pkg::vteStrobe_t strobe;

  vte_regs #(.HW(HW), .VW(VW), .PIX_W(PIX_W), .NCOMP(NCOMP)) u_regs (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pendHPer(pendHPer), .pendHPulse(pendHPulse), .pendHStart(pendHStart),
    .pendHEnd(pendHEnd), .pendFrame(pendFrame), .pendVsLen(pendVsLen),
    .pendVStart(pendVStart), .pendVEnd(pendVEnd), .pendSkew(pendSkew),
    .polBits(polBits), .borderColor(borderColor), .underColor(underColor),
    .fmtCodes(fmtCodes), .engEn(engEn), .cntEn(cntEn)
  );

  vte_ctrl #(.HW(HW), .VW(VW)) u_ctrl (
    .clk(clk), .rst(rst), .engEn(engEn),
    .pendHPer(pendHPer), .pendHPulse(pendHPulse), .pendHStart(pendHStart),
    .pendHEnd(pendHEnd), .pendFrame(pendFrame), .pendVsLen(pendVsLen),
    .pendVStart(pendVStart), .pendVEnd(pendVEnd), .pendSkew(pendSkew),
    .strobe(strobe)
  );

  vte_datapath #(.CW(CW), .NCOMP(NCOMP), .FW(FW), .LW(LW)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .polBits(polBits),
    .borderColor(borderColor), .underColor(underColor), .fmtCodes(fmtCodes),
    .cntEn(cntEn), .inValid(inValid), .inPixel(inPixel),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .deOut(deOut), .pixOut(pixOut),
    .frameCount(frameCount), .lineCount(lineCount)
  );

  assign inReady = strobe.de;
endmodule

// File: rtl/vte_chk.sv
module vte_chk #(
  parameter int FW = 16,
  parameter int LW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          inReady,
  input logic          deOut,
  input logic [FW-1:0] frameCount,
  input logic [LW-1:0] lineCount
);
  // R7
  ready_then_de_chk: assert property (@(posedge clk) disable iff (rst)
    inReady |=> deOut);

  // R4
  idle_then_no_de_chk: assert property (@(posedge clk) disable iff (rst)
    !inReady |=> !deOut);

  // R11
  frame_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(frameCount) |-> frameCount == FW'($past(frameCount) + 1'b1));

  // R12
  line_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(lineCount) |-> (lineCount == '0 || lineCount == LW'($past(lineCount) + 1'b1)));
endmodule

bind vid_timing_engine vte_chk #(.FW(FW), .LW(LW)) u_vte_chk (
  .clk(clk), .rst(rst), .inReady(inReady), .deOut(deOut),
  .frameCount(frameCount), .lineCount(lineCount)
);

// File: tb/test_vid_timing_engine.sv
module test_vid_timing_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic inValid = 1'b0;
  logic [23:0] inPixel = '0;
  logic inReady, hsyncOut, vsyncOut, deOut;
  logic [23:0] pixOut;
  logic [15:0] frameCount;
  logic [11:0] lineCount;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  vid_timing_engine i_vid_timing_engine (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .inValid(inValid), .inPixel(inPixel), .inReady(inReady),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .deOut(deOut), .pixOut(pixOut),
    .frameCount(frameCount), .lineCount(lineCount)
  );

  // ---------------- behavioural reference model ----------------
  int sh[7];   // pending: hPer, hPulse, hStart, hEnd, frame, vsLen, vStart ... see below
  int shVEnd, shSkew, acVEnd, acSkew;
  int ac[7];
  int mPol, mBorder, mUnder, mFmt, mEn, mCntEn;
  bit mRun;
  int mh, mv;
  int eH, eV, eDe, ePix, eFrame, eLine;

  function automatic int trunc8(int v, int code);
    int keep;
    keep = (code == 0) ? 4 : (code == 1) ? 5 : (code == 2) ? 6 : 8;
    return v & ((255 << (8 - keep)) & 255);
  endfunction

  function automatic int fmtPix(int p, int f);
    return trunc8(p & 255, f & 3) | (trunc8((p >> 8) & 255, (f >> 2) & 3) << 8)
         | (trunc8((p >> 16) & 255, (f >> 4) & 3) << 16);
  endfunction

  // ac/sh index: 0 hPer, 1 hPulse, 2 hStart, 3 hEnd, 4 frame, 5 vsLen, 6 vStart
  function automatic bit winNow();
    return mRun && mh >= ac[2] && mh <= ac[3]
        && mv >= ac[6] + acSkew && mv <= acVEnd + acSkew;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (sh[k]) begin sh[k] = 0; ac[k] = 0; end
      shVEnd = 0; shSkew = 0; acVEnd = 0; acSkew = 0;
      mPol = 0; mBorder = 0; mUnder = 0; mFmt = 63; mEn = 0; mCntEn = 0;
      mRun = 0; mh = 0; mv = 0;
      eH = 0; eV = 0; eDe = 0; ePix = 0; eFrame = 0; eLine = 0;
    end else begin
      bit de, fEnd, load;
      de   = winNow();
      eH   = (mRun && mh < ac[1]) ^ (mPol & 1);
      eV   = (mRun && mv < ac[5]) ^ ((mPol >> 1) & 1);
      eDe  = de;
      ePix = fmtPix(!de ? mBorder : (inValid ? int'(inPixel) : mUnder), mFmt);
      if ((mCntEn & 1) && mRun && mv == 0) eFrame = (eFrame + 1) & 16'hFFFF;
      if (mCntEn & 2) begin
        if (mRun && mv == 0) eLine = 0;
        else if (mRun && mh == 0) eLine = (eLine + 1) & 12'hFFF;
      end
      fEnd = mRun && (mv + 1 >= ac[4]);
      load = (!mRun && mEn != 0) || fEnd;
      if (load) begin
        foreach (ac[k]) ac[k] = sh[k];
        acVEnd = shVEnd; acSkew = shSkew;
        mh = 0; mv = 0;
      end else if (mRun) begin
        mh = (mh + 1 >= ac[0]) ? 0 : mh + 1;
        mv = mv + 1;
      end
      if (!mRun && mEn != 0) mRun = 1;
      else if (fEnd && mEn == 0) mRun = 0;
      if (wrEn) begin
        case (wrAddr)
          4'd0: begin sh[0] = wrData[11:0]; sh[1] = wrData[27:16]; end
          4'd1: sh[4] = wrData[23:0];
          4'd2: sh[5] = wrData[23:0];
          4'd3: begin sh[2] = wrData[11:0]; sh[3] = wrData[27:16]; end
          4'd4: sh[6] = wrData[23:0];
          4'd5: shVEnd = wrData[23:0];
          4'd6: shSkew = wrData[23:0];
          4'd7: mPol = wrData[1:0];
          4'd8: mBorder = wrData[23:0];
          4'd9: mUnder = wrData[23:0];
          4'd10: mFmt = wrData[5:0];
          4'd11: mEn = wrData[0];
          4'd12: mCntEn = wrData[1:0];
          default: ;
        endcase
      end
    end
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check("R2 R6 hsync", int'(hsyncOut), eH);
      check("R3 R6 R10 vsync", int'(vsyncOut), eV);
      check("R4 R5 R9 de", int'(deOut), eDe);
      check("R7 R8 pixel", int'(pixOut), ePix);
      check("R7 ready", int'(inReady), int'(winNow()));
      check("R11 frameCount", int'(frameCount), eFrame);
      check("R12 lineCount", int'(lineCount), eLine);
    end
  end

  // input pixel stream
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    inValid <= (cyc % 3) != 0 && (cyc % 17) != 5;
    inPixel <= 24'(cyc * 40503 + 7);
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int holdFrame;
    waitCycles(4);
    // R1: reset values observed while reset held
    check("R1 reset hsync", int'(hsyncOut), 0);
    check("R1 reset de", int'(deOut), 0);
    check("R1 reset pixel", int'(pixOut), 0);
    check("R1 reset ready", int'(inReady), 0);
    rst = 1'b0;
    waitCycles(3);
    check("R1 idle frameCount", int'(frameCount), 0);
    check("R1 idle vsync", int'(vsyncOut), 0);

    // 10 pixels per line, 6 lines per frame
    wr(4'd0, {16'd2, 16'd10});
    wr(4'd1, 32'd60);
    wr(4'd2, 32'd10);
    wr(4'd3, {16'd8, 16'd3});
    wr(4'd4, 32'd20);
    wr(4'd5, 32'd49);
    wr(4'd8, 32'h102030);
    wr(4'd9, 32'h0000FF);
    wr(4'd12, 32'd3);
    wr(4'd11, 32'd1);          // R9 start
    waitCycles(130);

    // R6 polarity, R8 depth codes 0/1/2, R5 skew (R10: skew waits for frame start)
    wr(4'd7, 32'd3);
    wr(4'd10, 32'b10_01_00);
    wr(4'd6, 32'd5);
    waitCycles(180);
    wr(4'd7, 32'd2);
    wr(4'd10, 32'b11_10_01);

    // R10: new line period and frame length written mid-frame
    waitCycles(23);
    wr(4'd0, {16'd3, 16'd12});
    wr(4'd1, 32'd72);
    wr(4'd3, {16'd10, 16'd1});
    wr(4'd4, 32'd12);
    wr(4'd5, 32'd59);
    wr(4'd6, 32'd0);
    waitCycles(230);

    // R12: line counter frozen when its enable bit clears
    wr(4'd12, 32'd1);
    waitCycles(80);

    // R9: disable mid-frame, frame completes then idle
    waitCycles(17);
    wr(4'd11, 32'd0);
    waitCycles(150);
    holdFrame = frameCount;
    waitCycles(100);
    check("R9 R11 idle holds frameCount", int'(frameCount), holdFrame);
    check("R9 idle ready low", int'(inReady), 0);

    // restart
    wr(4'd12, 32'd3);
    wr(4'd11, 32'd1);
    waitCycles(160);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule